// File: doc/BRIEF.md
# Edge-Qualified Event Debouncer

This block filters one raw condition signal, already synchronised to the clock, into a clean level and a single-cycle event strobe. The clean level drives a status sense bit. The strobe drives a sticky status bit in an interrupt controller. A transition of the raw input is accepted only after the new value has held for a configured number of time-base ticks. The tick is a one-cycle enable from a slow divider, for example one tick per millisecond. Rising and falling transitions each have their own tick count, and a count of zero lets that direction through with no filtering.

Each instance is given a trigger mode that decides which accepted transitions raise the event strobe: rising only, falling only, both, or none. The strobe is asserted in the same cycle that the clean level takes its new value. The reset state of the clean level is a parameter, and settling into that state never produces an event.

Top module: `edge_evt_debounce`

## Requirements
- R1: While reset is held and in the first cycle after it, `levelOut` equals `RESET_LEVEL` and `eventPulse` is 0. Leaving reset never produces an event on its own.
- R2: When `rawIn` is 1 and `levelOut` is 0, `levelOut` becomes 1 on the clock edge that samples the `RISE_TICKS`-th `tick` counted since `rawIn` last differed from `levelOut`. `rawIn` must stay 1 throughout this count.
- R3: When `rawIn` is 0 and `levelOut` is 1, `levelOut` becomes 0 on the clock edge that samples the `FALL_TICKS`-th `tick`, counted in the same way as for R2.
- R4: Any clock edge where `rawIn` equals `levelOut` discards the ticks counted so far. A later transition must then collect its full count again.
- R5: Only cycles with `tick` = 1 advance the count. With `tick` held at 0 and a non-zero period, `levelOut` does not change however long `rawIn` differs.
- R6: A direction whose period is 0 is not filtered. `levelOut` takes the new `rawIn` value at the next clock edge.
- R7: With `TRIG_MODE` = 2'b01, `eventPulse` is 1 exactly in the cycles where `levelOut` has just changed from 0 to 1.
- R8: With `TRIG_MODE` = 2'b10, `eventPulse` is 1 exactly in the cycles where `levelOut` has just changed from 1 to 0.
- R9: With `TRIG_MODE` = 2'b11, `eventPulse` is 1 exactly in the cycles where `levelOut` has just changed in either direction.
- R10: With `TRIG_MODE` = 2'b00, `eventPulse` stays 0.
- R11: `eventPulse` is 1 only in a cycle where `levelOut` differs from its value in the previous cycle. It lasts one cycle for each accepted transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable; each cycle it is high counts one unit of debounce time |
| rawIn | input | 1 | Synchronised raw condition |
| levelOut | output | 1 | Debounced level, for a sense bit |
| eventPulse | output | 1 | One-cycle event for an accepted, mode-qualified transition |

## Verification
A counter that fails to clear, or that keeps counting on cycles without a tick, shows up at `levelOut` as an acceptance a few ticks early or late. The bench's cycle model catches this on the first cycle the level differs. A wrong trigger-mode decode or a missing pulse register shows on `eventPulse` in the very cycle of the transition, or in the cycle after it. Four instances share one random stimulus: dual-edge, rising-only with a falling bypass, falling-only with both directions bypassed, and a silent one. Together they cover every mode and both delay regimes.

// File: rtl/edge_evt_pkg.sv
package edge_evt_pkg;

  // Trigger-mode encodings used by TRIG_MODE
  localparam logic [1:0] TRIG_NONE = 2'b00;
  localparam logic [1:0] TRIG_RISE = 2'b01;
  localparam logic [1:0] TRIG_FALL = 2'b10;
  localparam logic [1:0] TRIG_BOTH = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCount;  // input agrees with level: drop partial count
    logic incCount;  // one more qualifying tick seen
    logic commit;    // accept the new input level
    logic fire;      // accepted transition qualifies for an event
  } evtStrobes_t;

endpackage

// File: rtl/edge_evt_dp.sv
module edge_evt_dp
  import edge_evt_pkg::*;
#(
  parameter int   CNT_W       = 5,
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  evtStrobes_t      strobes,
  output logic             level,
  output logic [CNT_W-1:0] count,
  output logic             differs,
  output logic             eventPulse
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level      <= RESET_LEVEL;
      count      <= '0;
      eventPulse <= 1'b0;
    end else begin
      eventPulse <= strobes.fire;
      if (strobes.commit) begin
        level <= rawIn;
        count <= '0;
      end else if (strobes.clrCount) begin
        count <= '0;
      end else if (strobes.incCount) begin
        count <= count + 1'b1;
      end
    end
  end

  assign differs = (rawIn != level);

  // The level only ever moves towards the value the input had
  assert_level_tracks_input_R2: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> (level == $past(rawIn)));

  // A pulse only accompanies a real level change
  assert_pulse_on_change_R11: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> (level != $past(level)));

endmodule

// File: rtl/edge_evt_ctrl.sv
module edge_evt_ctrl
  import edge_evt_pkg::*;
#(
  parameter int         RISE_TICKS = 22,
  parameter int         FALL_TICKS = 10,
  parameter int         CNT_W      = 5,
  parameter logic [1:0] TRIG_MODE  = TRIG_BOTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             rawIn,
  input  logic             differs,
  input  logic [CNT_W-1:0] count,
  output evtStrobes_t      strobes
);

  localparam logic [CNT_W:0] RISE_P = RISE_TICKS[CNT_W:0];
  localparam logic [CNT_W:0] FALL_P = FALL_TICKS[CNT_W:0];

  logic [CNT_W:0] period;
  logic [CNT_W:0] nextCount;
  logic           accept;
  logic           dirOk;

  assign period    = rawIn ? RISE_P : FALL_P;
  assign nextCount = {1'b0, count} + 1'b1;

  // Acceptance decision for a pending transition
  always_comb begin
    accept = 1'b0;
    if (differs) begin
      if (period == '0)            accept = 1'b1;
      else if (tick && (nextCount >= period)) accept = 1'b1;
    end
  end

  // Direction qualifier selected by trigger mode
  generate
    if (TRIG_MODE == TRIG_RISE) begin : g_rise
      assign dirOk = rawIn;
    end else if (TRIG_MODE == TRIG_FALL) begin : g_fall
      assign dirOk = !rawIn;
    end else if (TRIG_MODE == TRIG_BOTH) begin : g_both
      assign dirOk = 1'b1;
    end else begin : g_none
      assign dirOk = 1'b0;
    end
  endgenerate

  always_comb begin
    strobes          = '0;
    strobes.clrCount = !differs;
    strobes.commit   = accept;
    strobes.incCount = differs && !accept && tick;
    strobes.fire     = accept && dirOk;
  end

  // An edge where input equals level leaves no partial count behind
  assert_glitch_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    !differs |=> (count == '0));

  // Without a tick a filtered transition makes no progress
  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (differs && !tick && (period != '0)) |=> (count == $past(count)));

endmodule

// File: rtl/edge_evt_debounce.sv
module edge_evt_debounce
  import edge_evt_pkg::*;
#(
  parameter int         RISE_TICKS  = 22,
  parameter int         FALL_TICKS  = 10,
  parameter logic [1:0] TRIG_MODE   = 2'b11,
  parameter logic       RESET_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rawIn,
  output logic levelOut,
  output logic eventPulse
);

  localparam int MAX_TICKS = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
  localparam int CNT_W     = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS + 1);

  evtStrobes_t      strobes;
  logic [CNT_W-1:0] count;
  logic             differs;

  edge_evt_ctrl #(
    .RISE_TICKS(RISE_TICKS),
    .FALL_TICKS(FALL_TICKS),
    .CNT_W     (CNT_W),
    .TRIG_MODE (TRIG_MODE)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .rawIn  (rawIn),
    .differs(differs),
    .count  (count),
    .strobes(strobes)
  );

  edge_evt_dp #(
    .CNT_W      (CNT_W),
    .RESET_LEVEL(RESET_LEVEL)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     (rawIn),
    .strobes   (strobes),
    .level     (levelOut),
    .count     (count),
    .differs   (differs),
    .eventPulse(eventPulse)
  );

  // Per-mode event qualification checks
  generate
    if (TRIG_MODE == TRIG_RISE) begin : g_chkRise
      assert_rise_only_R7: assert property (@(posedge clk) disable iff (!rstN)
        eventPulse |-> levelOut);
    end else if (TRIG_MODE == TRIG_FALL) begin : g_chkFall
      assert_fall_only_R8: assert property (@(posedge clk) disable iff (!rstN)
        eventPulse |-> !levelOut);
    end else if (TRIG_MODE == TRIG_BOTH) begin : g_chkBoth
      assert_every_change_R9: assert property (@(posedge clk) disable iff (!rstN)
        (levelOut != $past(levelOut)) |-> eventPulse);
    end else begin : g_chkNone
      assert_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
        !eventPulse);
    end
    if (RISE_TICKS == 0) begin : g_chkRiseBypass
      assert_rise_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
        (rawIn && !levelOut) |=> levelOut);
    end
    if (FALL_TICKS == 0) begin : g_chkFallBypass
      assert_fall_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!rawIn && levelOut) |=> !levelOut);
    end
  endgenerate

  // Reset leaves the declared level and no event
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (levelOut == RESET_LEVEL) && !eventPulse);

endmodule

// File: tb/edge_evt_debounce_test.sv
module edge_evt_debounce_test;

  localparam int NI = 4;
  localparam int RP[NI] = '{3, 2, 0, 1};
  localparam int FP[NI] = '{2, 0, 0, 1};
  localparam int MD[NI] = '{3, 1, 2, 0};
  localparam bit RL[NI] = '{1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic rawIn = 1'b0;
  logic [NI-1:0] dutLvl;
  logic [NI-1:0] dutPul;

  int errors = 0;
  int checks = 0;
  bit mLvl[NI];
  bit mPul[NI];
  int mCnt[NI];

  always #4 clk = ~clk;

  edge_evt_debounce #(.RISE_TICKS(3), .FALL_TICKS(2), .TRIG_MODE(2'b11), .RESET_LEVEL(1'b0)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .rawIn(rawIn), .levelOut(dutLvl[0]), .eventPulse(dutPul[0]));
  edge_evt_debounce #(.RISE_TICKS(2), .FALL_TICKS(0), .TRIG_MODE(2'b01), .RESET_LEVEL(1'b1)) uRise (
    .clk(clk), .rstN(rstN), .tick(tick), .rawIn(rawIn), .levelOut(dutLvl[1]), .eventPulse(dutPul[1]));
  edge_evt_debounce #(.RISE_TICKS(0), .FALL_TICKS(0), .TRIG_MODE(2'b10), .RESET_LEVEL(1'b0)) uFall (
    .clk(clk), .rstN(rstN), .tick(tick), .rawIn(rawIn), .levelOut(dutLvl[2]), .eventPulse(dutPul[2]));
  edge_evt_debounce #(.RISE_TICKS(1), .FALL_TICKS(1), .TRIG_MODE(2'b00), .RESET_LEVEL(1'b0)) uNone (
    .clk(clk), .rstN(rstN), .tick(tick), .rawIn(rawIn), .levelOut(dutLvl[3]), .eventPulse(dutPul[3]));

  function automatic string pulseTag(int m);
    case (m)
      1: return "R7";
      2: return "R8";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NI; i++) begin
      mLvl[i] = RL[i];
      mPul[i] = 1'b0;
      mCnt[i] = 0;
    end
  endtask

  // Behaviour stepped at a clock edge from the values present before it
  task automatic modelStep();
    for (int i = 0; i < NI; i++) begin
      int p;
      bit take;
      take = 1'b0;
      mPul[i] = 1'b0;
      p = rawIn ? RP[i] : FP[i];
      if (rawIn == mLvl[i]) mCnt[i] = 0;
      else if (p == 0) take = 1'b1;
      else if (tick) begin
        if (mCnt[i] + 1 >= p) take = 1'b1;
        else mCnt[i]++;
      end
      if (take) begin
        mLvl[i] = rawIn;
        mCnt[i] = 0;
        mPul[i] = (rawIn && MD[i][0]) || (!rawIn && MD[i][1]);
      end
    end
  endtask

  task automatic compareAll();
    for (int i = 0; i < NI; i++) begin
      int p;
      p = mLvl[i] ? FP[i] : RP[i];
      check((p == 0) ? "R6" : (mLvl[i] ? "R2" : "R3"), dutLvl[i], mLvl[i]);
      check(pulseTag(MD[i]), dutPul[i], mPul[i]);
    end
  endtask

  // Drive at a falling edge, advance model at rising edge, compare at next falling edge
  task automatic cyc(input bit r, input bit t);
    rawIn = r;
    tick  = t;
    @(posedge clk);
    if (rstN) modelStep();
    else modelReset();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    modelReset();
    @(negedge clk);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1);
    // R1: state held in reset
    for (int i = 0; i < NI; i++) begin
      check("R1", dutLvl[i], RL[i]);
      check("R1", dutPul[i], 0);
    end
    rstN = 1'b1;
    cyc(1'b0, 1'b0);
    check("R1", dutLvl[0], 0);
    check("R1", dutPul[1], 0);

    // R5: no ticks, no progress
    for (int k = 0; k < 12; k++) cyc(1'b1, 1'b0);
    check("R5", dutLvl[0], 0);
    // R4: two ticks, glitch back, then two more ticks is not enough
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    check("R4", dutLvl[0], 0);
    // R2: third tick after restart accepts, pulse in same cycle
    cyc(1'b1, 1'b1);
    check("R2", dutLvl[0], 1);
    check("R11", dutPul[0], 1);
    cyc(1'b1, 1'b1);
    check("R11", dutPul[0], 0);
    // R3: falling period of two ticks
    cyc(1'b0, 1'b1);
    check("R3", dutLvl[0], 1);
    check("R6", dutLvl[2], 0);
    cyc(1'b0, 1'b1);
    check("R3", dutLvl[0], 0);
    check("R9", dutPul[0], 1);

    // Random phase
    for (int k = 0; k < 5000; k++) begin
      bit r;
      r = rawIn;
      if ($urandom_range(0, 5) == 0) r = !r;
      cyc(r, ($urandom_range(0, 1) == 1));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule